// File: doc/BRIEF.md
# Scanner Image Memory Address Generator

This block drives the address pins of a byte-wide external SRAM used by a document scanner. The bottom of the memory holds the per-pixel correction table: 16-bit offset and gain words for three colours. All memory above that table is a circular image buffer. Pixel data from the scan pipeline goes into this buffer, and the host reads the data back out of it. The block keeps the write and read pointers of the ring. It reports whether the ring is full, so scanning can pause, and whether it is empty. It also serves correction-table lookups by index.

The correction table has two sizes. The low-resolution setting uses 2^COEF_LO_LOG2 bytes (16K by default). The high-resolution setting uses 2^COEF_HI_LOG2 bytes (32K by default). There are three memory-size modes. In the two smaller modes the top address pin that is in use is paired with an inverted copy on the pin above it, so two half-size devices can take those two pins directly as chip selects. Only one access is issued per cycle. A registered valid flag marks each cycle that carries a new address. The configuration inputs are meant to be set before a reset and held until the next reset.

Top module: `scan_sram_addr`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `addr_valid`, `buf_full` and `cfg_err` are 0 and `buf_empty` is 1. Both pointers start at the ring base.
- R2: The ring base is 2^COEF_LO_LOG2 when `hi_res`=0 and 2^COEF_HI_LOG2 when `hi_res`=1. A correction access uses `coef_idx` as the logical address. When `hi_res`=0, the index bits at position COEF_LO_LOG2 and above are ignored.
- R3: Each accepted pixel write is issued at the write pointer. The pointer then advances by one, and it wraps from the top logical address of the selected size back to the ring base.
- R4: Each accepted host read is issued at the read pointer. The read pointer advances and wraps in the same way as the write pointer.
- R5: `buf_full` is 1 exactly when one more write advance would make the write pointer equal to the read pointer. A write strobe while the ring is full issues no write and leaves the write pointer unchanged.
- R6: `buf_empty` is 1 exactly when the two pointers are equal. A read strobe while the ring is empty issues no read.
- R7: With `size_mode`=0 (64K), the logical address occupies pins [PIN_W-3:0], pin PIN_W-2 is the inverse of pin PIN_W-3, and pin PIN_W-1 is 0.
- R8: With `size_mode`=1 (128K), the logical address occupies pins [PIN_W-2:0], and pin PIN_W-1 is the inverse of pin PIN_W-2.
- R9: With `size_mode`=2 (256K), every pin carries the logical address bit of the same position.
- R10: `size_mode`=3, or `size_mode`=0 together with `hi_res`=1, is a bad configuration. `cfg_err` rises one cycle after such a configuration is present, and while it is present every strobe is ignored: no access is issued and the pointers hold.
- R11: At most one access is accepted per cycle, in priority order correction lookup, then write, then read. A write refused because the ring is full yields the cycle to a pending read. The address and `addr_valid`=1 appear on the clock edge that accepts the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_mode | input | 2 | Memory size: 0=64K, 1=128K, 2=256K, 3=reserved |
| hi_res | input | 1 | 1 selects the larger correction table |
| coef_req | input | 1 | Correction-table lookup request |
| coef_idx | input | COEF_HI_LOG2 | Byte index into the correction table |
| wr_stb | input | 1 | Pixel write request |
| rd_stb | input | 1 | Host read request |
| sram_addr | output | PIN_W | Registered physical address pins |
| addr_valid | output | 1 | `sram_addr` holds a newly issued access |
| buf_full | output | 1 | Ring cannot accept another write |
| buf_empty | output | 1 | Ring holds no unread data |
| cfg_err | output | 1 | Bad size/resolution combination |

## Verification
Some properties are checked by assertions on every cycle. These cover the pin pairing of the two split-device modes, pointers that never leave the ring, full and empty never being asserted together, no pointer movement on a refused write or read, and no access while the configuration is bad. The exact address sequence cannot be checked that way, because it needs a model: the wrap from the top address back to the base, the base for each resolution, the index masking, and the fill and drain counts that set the full and empty flags. The bench covers these by sweeping every legal size and resolution pair on a reduced pin width, with expected addresses computed arithmetically. The same holds for the priority decisions between competing strobes.

// File: rtl/scan_sram_pkg.sv
package scan_sram_pkg;

  typedef enum logic [1:0] {
    SZ_64K  = 2'd0,
    SZ_128K = 2'd1,
    SZ_256K = 2'd2,
    SZ_RSVD = 2'd3
  } size_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_COEF = 2'd1,
    ACC_WR   = 2'd2,
    ACC_RD   = 2'd3
  } acc_e;

endpackage

// File: rtl/scan_cfg_decode.sv
module scan_cfg_decode
  import scan_sram_pkg::*;
#(
  parameter int PIN_W        = 18,
  parameter int COEF_LO_LOG2 = 14,
  parameter int COEF_HI_LOG2 = 15
) (
  input  size_mode_e       size_mode,
  input  logic             hi_res,
  output logic [PIN_W-1:0] ring_base,
  output logic [PIN_W-1:0] ring_last,
  output logic [PIN_W-1:0] coef_mask,
  output logic             bad_cfg
);

  localparam logic [PIN_W-1:0] ONE      = {{(PIN_W-1){1'b0}}, 1'b1};
  localparam logic [PIN_W-1:0] BASE_LO  = ONE << COEF_LO_LOG2;
  localparam logic [PIN_W-1:0] BASE_HI  = ONE << COEF_HI_LOG2;
  localparam logic [PIN_W-1:0] ALL_ONES = {PIN_W{1'b1}};
  localparam logic [PIN_W-1:0] LAST_S   = ALL_ONES >> 2;
  localparam logic [PIN_W-1:0] LAST_M   = ALL_ONES >> 1;

  always_comb begin
    ring_base = hi_res ? BASE_HI : BASE_LO;
    coef_mask = ring_base - ONE;
    unique case (size_mode)
      SZ_64K:  ring_last = LAST_S;
      SZ_128K: ring_last = LAST_M;
      default: ring_last = ALL_ONES;
    endcase
    bad_cfg = (size_mode == SZ_RSVD) || ((size_mode == SZ_64K) && hi_res);
  end

endmodule

// File: rtl/scan_ring_ptr.sv
module scan_ring_ptr #(
  parameter int PIN_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] ring_base,
  input  logic [PIN_W-1:0] ring_last,
  input  logic             adv,
  output logic [PIN_W-1:0] ptr,
  output logic [PIN_W-1:0] ptr_inc
);

  always_comb begin
    ptr_inc = (ptr == ring_last) ? ring_base : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= ring_base;
    else if (adv) ptr <= ptr_inc;
  end

  // R3 / R4: the pointer always stays inside the ring
  a_r3_ptr_in_ring: assert property (@(posedge clk) disable iff (rst)
    (ptr >= ring_base) && (ptr <= ring_last))
    else $error("pointer left the ring");

endmodule

// File: rtl/scan_pin_map.sv
module scan_pin_map
  import scan_sram_pkg::*;
#(
  parameter int PIN_W = 18
) (
  input  size_mode_e       size_mode,
  input  logic [PIN_W-1:0] logical,
  output logic [PIN_W-1:0] phys
);

  localparam logic [PIN_W-1:0] MASK_S = {PIN_W{1'b1}} >> 2;
  localparam logic [PIN_W-1:0] MASK_M = {PIN_W{1'b1}} >> 1;

  always_comb begin
    unique case (size_mode)
      SZ_64K: begin
        phys            = logical & MASK_S;
        phys[PIN_W-2]   = ~logical[PIN_W-3];
        phys[PIN_W-1]   = 1'b0;
      end
      SZ_128K: begin
        phys            = logical & MASK_M;
        phys[PIN_W-1]   = ~logical[PIN_W-2];
      end
      default: phys = logical;
    endcase
  end

endmodule

// File: rtl/scan_sram_addr.sv
module scan_sram_addr
  import scan_sram_pkg::*;
#(
  parameter int PIN_W        = 18,
  parameter int COEF_LO_LOG2 = 14,
  parameter int COEF_HI_LOG2 = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              size_mode,
  input  logic                    hi_res,
  input  logic                    coef_req,
  input  logic [COEF_HI_LOG2-1:0] coef_idx,
  input  logic                    wr_stb,
  input  logic                    rd_stb,
  output logic [PIN_W-1:0]        sram_addr,
  output logic                    addr_valid,
  output logic                    buf_full,
  output logic                    buf_empty,
  output logic                    cfg_err
);

  size_mode_e       mode;
  logic [PIN_W-1:0] ring_base, ring_last, coef_mask;
  logic             bad_cfg;
  logic [PIN_W-1:0] wr_ptr, wr_inc, rd_ptr, rd_inc;
  logic [PIN_W-1:0] coef_log, sel_log, sel_phys;
  logic             do_coef, do_wr, do_rd;
  acc_e             acc;

  assign mode = size_mode_e'(size_mode);

  scan_cfg_decode #(
    .PIN_W(PIN_W), .COEF_LO_LOG2(COEF_LO_LOG2), .COEF_HI_LOG2(COEF_HI_LOG2)
  ) u_cfg (
    .size_mode(mode), .hi_res(hi_res), .ring_base(ring_base),
    .ring_last(ring_last), .coef_mask(coef_mask), .bad_cfg(bad_cfg)
  );

  scan_ring_ptr #(.PIN_W(PIN_W)) u_wptr (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_last(ring_last),
    .adv(do_wr), .ptr(wr_ptr), .ptr_inc(wr_inc)
  );

  scan_ring_ptr #(.PIN_W(PIN_W)) u_rptr (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_last(ring_last),
    .adv(do_rd), .ptr(rd_ptr), .ptr_inc(rd_inc)
  );

  // flags come straight from the registered pointers
  always_comb begin
    buf_empty = (wr_ptr == rd_ptr);
    buf_full  = (wr_inc == rd_ptr);
  end

  // one grant per cycle: lookup, then write, then read
  always_comb begin
    do_coef = !bad_cfg && coef_req;
    do_wr   = !bad_cfg && !coef_req && wr_stb && !buf_full;
    do_rd   = !bad_cfg && !coef_req && !do_wr && rd_stb && !buf_empty;
    if (do_coef)    acc = ACC_COEF;
    else if (do_wr) acc = ACC_WR;
    else if (do_rd) acc = ACC_RD;
    else            acc = ACC_NONE;
  end

  always_comb begin
    coef_log = {{(PIN_W-COEF_HI_LOG2){1'b0}}, coef_idx} & coef_mask;
    unique case (acc)
      ACC_COEF: sel_log = coef_log;
      ACC_WR:   sel_log = wr_ptr;
      ACC_RD:   sel_log = rd_ptr;
      default:  sel_log = '0;
    endcase
  end

  scan_pin_map #(.PIN_W(PIN_W)) u_map (
    .size_mode(mode), .logical(sel_log), .phys(sel_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      addr_valid <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      cfg_err    <= bad_cfg;
      addr_valid <= (acc != ACC_NONE);
      if (acc != ACC_NONE) sram_addr <= sel_phys;
    end
  end

  // R5: full and empty never together
  a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(buf_full && buf_empty))
    else $error("full and empty together");

  // R5: write refused while full
  a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    (buf_full && wr_stb && !coef_req) |=> $stable(wr_ptr))
    else $error("write pointer moved while full");

  // R6: read refused while empty
  a_r6_no_read_when_empty: assert property (@(posedge clk) disable iff (rst)
    (buf_empty && rd_stb && !coef_req && !wr_stb) |=> $stable(rd_ptr))
    else $error("read pointer moved while empty");

  // R4: read pointer takes the wrapped successor
  a_r4_read_step: assert property (@(posedge clk) disable iff (rst)
    do_rd |=> (rd_ptr == $past(rd_inc)))
    else $error("read pointer step wrong");

  // R7: split pins in 64K mode
  a_r7_pin_pair_small: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && mode == SZ_64K && !cfg_err) |->
      (sram_addr[PIN_W-2] != sram_addr[PIN_W-3]) && !sram_addr[PIN_W-1])
    else $error("64K pin pairing broken");

  // R8: split pins in 128K mode
  a_r8_pin_pair_mid: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && mode == SZ_128K) |->
      (sram_addr[PIN_W-1] != sram_addr[PIN_W-2]))
    else $error("128K pin pairing broken");

  // R10: no access while configuration is bad
  a_r10_err_no_access: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !addr_valid)
    else $error("access issued under bad config");

  // R11: a lookup under good config is always served
  a_r11_coef_served: assert property (@(posedge clk) disable iff (rst)
    (coef_req && !bad_cfg) |=> addr_valid)
    else $error("lookup not served");

endmodule

// File: tb/scan_sram_addr_tb.sv
module scan_sram_addr_tb;

  localparam int PIN_W = 8;
  localparam int LO    = 4;
  localparam int HI    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    size_mode = 2'd0;
  logic          hi_res = 1'b0;
  logic          coef_req = 1'b0;
  logic [HI-1:0] coef_idx = '0;
  logic          wr_stb = 1'b0;
  logic          rd_stb = 1'b0;
  logic [PIN_W-1:0] sram_addr;
  logic          addr_valid, buf_full, buf_empty, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_mode, m_base, m_last, wp, rp;

  always #10 clk = ~clk;

  scan_sram_addr #(.PIN_W(PIN_W), .COEF_LO_LOG2(LO), .COEF_HI_LOG2(HI)) u_dut (
    .clk(clk), .rst(rst), .size_mode(size_mode), .hi_res(hi_res),
    .coef_req(coef_req), .coef_idx(coef_idx), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .sram_addr(sram_addr), .addr_valid(addr_valid), .buf_full(buf_full),
    .buf_empty(buf_empty), .cfg_err(cfg_err)
  );

  function automatic int phys(input int mode, input int l);
    int p;
    case (mode)
      0: begin p = l % 64; if (((l >> 5) & 1) == 0) p = p + 64; end
      1: begin p = l % 128; if (((l >> 6) & 1) == 0) p = p + 128; end
      default: p = l;
    endcase
    return p;
  endfunction

  function automatic string map_tag(input int mode);
    return (mode == 0) ? "R7" : (mode == 1) ? "R8" : "R9";
  endfunction

  function automatic int nxt(input int p);
    return (p == m_last) ? m_base : p + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit w, input bit r, input int idx);
    coef_req = c; wr_stb = w; rd_stb = r; coef_idx = idx[HI-1:0];
    @(negedge clk);
    coef_req = 0; wr_stb = 0; rd_stb = 0;
  endtask

  task automatic do_reset(input int mode, input bit hr);
    rst = 1; size_mode = mode[1:0]; hi_res = hr;
    @(negedge clk); @(negedge clk);
    // R1
    chk(addr_valid == 0 && buf_full == 0 && buf_empty == 1 && cfg_err == 0, "R1",
        {addr_valid, buf_full, buf_empty, cfg_err}, 4'b0010);
    rst = 0;
    m_mode = mode; m_base = hr ? 32 : 16; m_last = (64 << mode) - 1;
    wp = m_base; rp = m_base;
  endtask

  task automatic expect_acc(input string req, input int logical);
    chk(addr_valid == 1, req, addr_valid, 1);
    chk(int'(sram_addr) == phys(m_mode, logical), req, sram_addr, phys(m_mode, logical));
  endtask

  task automatic run_cfg(input int mode, input bit hr);
    int ring;
    do_reset(mode, hr);
    ring = m_last - m_base + 1;
    // R2: lookups over the whole index space
    for (int i = 0; i < 32; i++) begin
      step(1, 0, 0, i);
      expect_acc("R2", hr ? i : (i % 16));
    end
    // R3: fill the ring
    for (int i = 0; i < ring - 1; i++) begin
      step(0, 1, 0, 0);
      expect_acc(i == 0 ? "R3" : map_tag(mode), wp);
      wp = nxt(wp);
    end
    chk(buf_full == 1 && buf_empty == 0, "R5", buf_full, 1);
    step(0, 1, 0, 0);
    chk(addr_valid == 0 && buf_full == 1, "R5", addr_valid, 0);
    // R11: lookup beats write and read
    step(1, 1, 1, 3);
    expect_acc("R11", 3);
    // R11: refused write yields to read
    step(0, 1, 1, 0);
    expect_acc("R11", rp);
    rp = nxt(rp);
    // R4: drain
    while (rp != wp) begin
      step(0, 0, 1, 0);
      expect_acc("R4", rp);
      rp = nxt(rp);
    end
    chk(buf_empty == 1 && buf_full == 0, "R6", buf_empty, 1);
    step(0, 0, 1, 0);
    chk(addr_valid == 0 && buf_empty == 1, "R6", addr_valid, 0);
    // R3/R4: wrap across the top
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 0, 0);
      expect_acc("R3", wp);
      wp = nxt(wp);
    end
    // R11: write beats read
    step(0, 1, 1, 0);
    expect_acc("R11", wp);
    wp = nxt(wp);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 0);
      expect_acc("R4", rp);
      rp = nxt(rp);
    end
    chk(buf_empty == 1, "R6", buf_empty, 1);
    chk(cfg_err == 0, "R10", cfg_err, 0);
  endtask

  task automatic run_bad(input int mode, input bit hr);
    do_reset(mode, hr);
    step(0, 1, 0, 0);
    chk(cfg_err == 1, "R10", cfg_err, 1);
    chk(addr_valid == 0, "R10", addr_valid, 0);
    step(1, 0, 1, 5);
    chk(addr_valid == 0, "R10", addr_valid, 0);
    step(0, 1, 1, 0);
    chk(addr_valid == 0 && buf_empty == 1, "R10", addr_valid, 0);
  endtask

  initial begin
    @(negedge clk);
    run_cfg(0, 0);
    run_cfg(1, 0);
    run_cfg(1, 1);
    run_cfg(2, 0);
    run_cfg(2, 1);
    run_bad(0, 1);
    run_bad(3, 0);
    run_bad(3, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule